// File: doc/BRIEF.md
# Page-Keyed Access Histogram Monitor

This block watches a stream of memory transactions on an interconnect link and counts how often each memory page is touched by each target node. It never stalls the link: the snoop input has no ready signal, and every transaction seen outside a flush is counted in the same cycle it arrives. The counts live in a small pool of counter slots. Each slot is tagged with a (page, node) pair and is searched like a fully associative cache.

A slot leaves the pool as a record of page, node and count in three cases: the pool is full and a new tag needs room, a counter is about to saturate, or software asks for a flush. The record goes through a simple write port into a circular buffer in memory. The monitor keeps the buffer's write and read pointers and fill level, and software frees entries with a pop strobe. When the buffer is full, the record is discarded rather than blocking. A sticky flag and a loss counter report that this happened. A slot freed by a capacity or saturation eviction goes straight back into service.

Top module: `access_hist_mon`

## Requirements
- R1: The snoop input has no backpressure. Every valid snoop seen while no flush walk is active updates the histogram in that cycle.
- R2: A counter's tag is the page number, `snoop_addr[ADDR_W-1:PAGE_SHIFT]`, together with `snoop_node`. Addresses that differ only in the low PAGE_SHIFT bits share a counter. The same page accessed from different nodes uses separate counters.
- R3: On a miss with a free slot, the lowest-numbered free slot takes the new tag with a count of 1.
- R4: On a miss with all slots valid, the slot under a round-robin pointer is evicted. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such eviction. The evicted slot's old tag and count form the record, and the slot is reloaded with the new tag and a count of 1.
- R5: A hit that would bring a counter to 2^CNT_W-2 writes a record with that count instead. The slot keeps its tag and restarts at 0.
- R6: A record appears on `rec_wr_en`/`rec_page`/`rec_node`/`rec_count` in the cycle after the event that caused it, at `rec_wr_addr` equal to the previous `ring_head`. Then `ring_head` advances by one modulo 2^RING_AW, and `ring_level` rises by one.
- R7: `ring_pop` advances `ring_tail` and lowers `ring_level` by one when the level is non-zero. When the level is zero, it has no effect.
- R8: With `ring_level` equal to 2^RING_AW, an eviction writes nothing. Instead it sets `lost_flag`, which stays set until reset, and adds one to `drop_count`, which saturates.
- R9: A `flush_req` seen while idle starts a walk on the next cycle. The walk visits slots 0 to SLOTS-1, one per cycle, and evicts and invalidates each valid slot. `flush_busy` is high during the walk. `flush_done` pulses for one cycle together with the record from the last slot, and the pool is then empty.
- R10: A valid snoop during a flush walk changes no counter and adds one to `drop_count`.
- R11: After reset, all slots are empty, no record is written, the pointers and level are 0, and `lost_flag`, `drop_count`, `flush_busy` and `flush_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_valid | input | 1 | Observed transaction present |
| snoop_addr | input | ADDR_W | Transaction address |
| snoop_node | input | NODE_W | Transaction target node |
| flush_req | input | 1 | Start a flush walk |
| ring_pop | input | 1 | Software consumed one record |
| rec_wr_en | output | 1 | Record write strobe |
| rec_wr_addr | output | RING_AW | Buffer slot written |
| rec_page | output | ADDR_W-PAGE_SHIFT | Record page number |
| rec_node | output | NODE_W | Record node |
| rec_count | output | CNT_W | Record access count |
| ring_head | output | RING_AW | Next write position |
| ring_tail | output | RING_AW | Next read position |
| ring_level | output | RING_AW+1 | Records held in buffer |
| lost_flag | output | 1 | Sticky: a record was discarded |
| drop_count | output | DROP_W | Discarded records and ignored snoops |
| flush_busy | output | 1 | Flush walk in progress |
| flush_done | output | 1 | Flush walk finished this cycle |

## Verification
The assertions assume that `ring_pop` is raised only against records software actually holds and that reset is applied before the first transaction. They also assume the stimulus never needs more than one eviction per cycle, which holds because only one snoop can arrive per cycle. The bench keeps its page and node values inside the configured widths. It issues flushes only from idle or lets the block ignore them while busy, so every sequence stays in the space the properties cover. A cycle-level model in the bench tracks the same tag pool and buffer arithmetic, and it is compared on every cycle of directed and swept traffic.

// File: rtl/access_hist_mon.sv
module access_hist_mon #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 8,
  parameter int NODE_W     = 2,
  parameter int SLOTS      = 4,
  parameter int CNT_W      = 4,
  parameter int RING_AW    = 3,
  parameter int DROP_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snoop_valid,
  input  logic [ADDR_W-1:0]            snoop_addr,
  input  logic [NODE_W-1:0]            snoop_node,
  input  logic                         flush_req,
  input  logic                         ring_pop,
  output logic                         rec_wr_en,
  output logic [RING_AW-1:0]           rec_wr_addr,
  output logic [ADDR_W-PAGE_SHIFT-1:0] rec_page,
  output logic [NODE_W-1:0]            rec_node,
  output logic [CNT_W-1:0]             rec_count,
  output logic [RING_AW-1:0]           ring_head,
  output logic [RING_AW-1:0]           ring_tail,
  output logic [RING_AW:0]             ring_level,
  output logic                         lost_flag,
  output logic [DROP_W-1:0]            drop_count,
  output logic                         flush_busy,
  output logic                         flush_done
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [RING_AW:0] RING_DEPTH = (RING_AW+1)'(1 << RING_AW);

  logic [SLOTS-1:0]  vld;
  logic [PAGE_W-1:0] tag_page [SLOTS];
  logic [NODE_W-1:0] tag_node [SLOTS];
  logic [CNT_W-1:0]  cnt      [SLOTS];
  logic [SLOT_W-1:0] rr, fptr;

  wire [PAGE_W-1:0] s_page = snoop_addr[ADDR_W-1:PAGE_SHIFT];
  wire s_act = snoop_valid && !flush_busy;

  logic              hit, free_any;
  logic [SLOT_W-1:0] hit_idx, free_idx;

  always_comb begin
    hit = 1'b0; hit_idx = '0; free_any = 1'b0; free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vld[i] && tag_page[i] == s_page && tag_node[i] == snoop_node) begin
        hit = 1'b1; hit_idx = SLOT_W'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1; free_idx = SLOT_W'(i);
      end
    end
  end

  wire [CNT_W-1:0] cnt_inc  = cnt[hit_idx] + 1'b1;
  wire             at_limit = cnt_inc == CNT_LIMIT;

  logic              ev_en;
  logic [PAGE_W-1:0] ev_page;
  logic [NODE_W-1:0] ev_node;
  logic [CNT_W-1:0]  ev_cnt;

  always_comb begin
    ev_en = 1'b0; ev_page = tag_page[fptr]; ev_node = tag_node[fptr]; ev_cnt = cnt[fptr];
    if (flush_busy) begin
      ev_en = vld[fptr];
    end else if (snoop_valid && hit && at_limit) begin
      ev_en = 1'b1; ev_page = s_page; ev_node = snoop_node; ev_cnt = CNT_LIMIT;
    end else if (snoop_valid && !hit && !free_any) begin
      ev_en = 1'b1; ev_page = tag_page[rr]; ev_node = tag_node[rr]; ev_cnt = cnt[rr];
    end
  end

  wire ring_full = ring_level == RING_DEPTH;
  wire push      = ev_en && !ring_full;
  wire pop_ok    = ring_pop && ring_level != '0;
  wire lose      = ev_en && ring_full;
  wire ignore    = snoop_valid && flush_busy;

  wire [1:0]        drop_inc = {1'b0, lose} + {1'b0, ignore};
  wire [DROP_W:0]   drop_sum = {1'b0, drop_count} + (DROP_W+1)'(drop_inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        tag_page[i] <= '0; tag_node[i] <= '0; cnt[i] <= '0;
      end
      rr <= '0; fptr <= '0;
      rec_wr_en <= 1'b0; rec_wr_addr <= '0; rec_page <= '0; rec_node <= '0; rec_count <= '0;
      ring_head <= '0; ring_tail <= '0; ring_level <= '0;
      lost_flag <= 1'b0; drop_count <= '0;
      flush_busy <= 1'b0; flush_done <= 1'b0;
    end else begin
      rec_wr_en <= push;
      if (push) begin
        rec_wr_addr <= ring_head;
        rec_page    <= ev_page;
        rec_node    <= ev_node;
        rec_count   <= ev_cnt;
        ring_head   <= ring_head + 1'b1;
      end
      if (pop_ok) ring_tail <= ring_tail + 1'b1;
      ring_level <= ring_level + {{RING_AW{1'b0}}, push} - {{RING_AW{1'b0}}, pop_ok};
      if (lose) lost_flag <= 1'b1;
      drop_count <= drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];

      if (flush_busy) begin
        vld[fptr] <= 1'b0;
      end else if (snoop_valid) begin
        if (hit) begin
          cnt[hit_idx] <= at_limit ? '0 : cnt_inc;
        end else if (free_any) begin
          vld[free_idx]      <= 1'b1;
          tag_page[free_idx] <= s_page;
          tag_node[free_idx] <= snoop_node;
          cnt[free_idx]      <= CNT_W'(1);
        end else begin
          tag_page[rr] <= s_page;
          tag_node[rr] <= snoop_node;
          cnt[rr]      <= CNT_W'(1);
          rr           <= (rr == LAST_SLOT) ? '0 : rr + 1'b1;
        end
      end

      flush_done <= flush_busy && fptr == LAST_SLOT;
      if (flush_busy) begin
        fptr <= (fptr == LAST_SLOT) ? '0 : fptr + 1'b1;
        if (fptr == LAST_SLOT) flush_busy <= 1'b0;
      end else if (flush_req) begin
        flush_busy <= 1'b1;
        fptr       <= '0;
      end
    end
  end

  wire unused_ok = s_act;
endmodule

module access_hist_mon_chk #(
  parameter int RING_AW = 3,
  parameter int CNT_W   = 4,
  parameter int DROP_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rec_wr_en,
  input logic [RING_AW-1:0] rec_wr_addr,
  input logic [CNT_W-1:0]   rec_count,
  input logic [RING_AW-1:0] ring_head,
  input logic [RING_AW:0]   ring_level,
  input logic               lost_flag,
  input logic [DROP_W-1:0]  drop_count,
  input logic               flush_busy,
  input logic               flush_done
);
  localparam logic [RING_AW:0] DEPTH = (RING_AW+1)'(1 << RING_AW);
  localparam logic [CNT_W-1:0] LIMIT = {{(CNT_W-1){1'b1}}, 1'b0};

  p_head_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr_en |-> ring_head == rec_wr_addr + 1'b1);
  p_level_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_level <= DEPTH);
  p_write_needs_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr_en |-> $past(ring_level) < DEPTH);
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_flag |=> lost_flag);
  p_drop_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count >= $past(drop_count));
  p_count_capped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr_en |-> rec_count <= LIMIT);
  p_done_ends_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !flush_busy && $past(flush_busy));
endmodule

bind access_hist_mon access_hist_mon_chk #(.RING_AW(RING_AW), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_wr_en(rec_wr_en), .rec_wr_addr(rec_wr_addr),
  .rec_count(rec_count), .ring_head(ring_head), .ring_level(ring_level),
  .lost_flag(lost_flag), .drop_count(drop_count), .flush_busy(flush_busy),
  .flush_done(flush_done)
);

// File: tb/access_hist_mon_bench.sv
module access_hist_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int LIMIT = 14;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic snoop_valid = 0, flush_req = 0, ring_pop = 0;
  logic [15:0] snoop_addr = '0;
  logic [1:0]  snoop_node = '0;
  logic rec_wr_en, lost_flag, flush_busy, flush_done;
  logic [2:0] rec_wr_addr, ring_head, ring_tail;
  logic [7:0] rec_page, drop_count;
  logic [1:0] rec_node;
  logic [3:0] rec_count, ring_level;

  access_hist_mon u_access_hist_mon (
    .clk(clk), .rst_n(rst_n), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_node(snoop_node), .flush_req(flush_req), .ring_pop(ring_pop),
    .rec_wr_en(rec_wr_en), .rec_wr_addr(rec_wr_addr), .rec_page(rec_page),
    .rec_node(rec_node), .rec_count(rec_count), .ring_head(ring_head),
    .ring_tail(ring_tail), .ring_level(ring_level), .lost_flag(lost_flag),
    .drop_count(drop_count), .flush_busy(flush_busy), .flush_done(flush_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit mv[SLOTS]; int mpage[SLOTS], mnode[SLOTS], mcnt[SLOTS];
  int mrr = 0, mhead = 0, mtail = 0, mlevel = 0, mdrop = 0, mfptr = 0;
  bit mlost = 0, mflush = 0;
  bit e_wr, e_done; int e_addr, e_page, e_node, e_cnt;
  int cap_page[1024], cap_node[1024], cap_cnt[1024]; int cap_n = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mstep(bit v, int a, int n, bit fl, bit pop);
    int pg = (a >> 8) & 255;
    bit h = 0, fa = 0, ev = 0; int hi = 0, fi = 0; int ep = 0, en = 0, ec = 0;
    bit full = (mlevel == DEPTH); int inc = 0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mv[i] && mpage[i] == pg && mnode[i] == n) begin h = 1; hi = i; end
      if (!mv[i]) begin fa = 1; fi = i; end
    end
    if (mflush) begin
      if (mv[mfptr]) begin ev = 1; ep = mpage[mfptr]; en = mnode[mfptr]; ec = mcnt[mfptr]; end
    end else if (v && h && mcnt[hi] + 1 == LIMIT) begin
      ev = 1; ep = pg; en = n; ec = LIMIT;
    end else if (v && !h && !fa) begin
      ev = 1; ep = mpage[mrr]; en = mnode[mrr]; ec = mcnt[mrr];
    end
    e_wr = ev && !full;
    if (e_wr) begin e_addr = mhead; e_page = ep; e_node = en; e_cnt = ec; mhead = (mhead + 1) % DEPTH; end
    if (ev && full) begin mlost = 1; inc++; end
    if (v && mflush) inc++;
    mdrop = (mdrop + inc > 255) ? 255 : mdrop + inc;
    mlevel = mlevel + (e_wr ? 1 : 0);
    if (pop && mlevel - (e_wr ? 1 : 0) > 0) begin mlevel--; mtail = (mtail + 1) % DEPTH; end
    if (mflush) mv[mfptr] = 0;
    else if (v) begin
      if (h) mcnt[hi] = (mcnt[hi] + 1 == LIMIT) ? 0 : mcnt[hi] + 1;
      else if (fa) begin mv[fi] = 1; mpage[fi] = pg; mnode[fi] = n; mcnt[fi] = 1; end
      else begin mpage[mrr] = pg; mnode[mrr] = n; mcnt[mrr] = 1; mrr = (mrr + 1) % SLOTS; end
    end
    e_done = mflush && mfptr == SLOTS - 1;
    if (mflush) begin
      if (mfptr == SLOTS - 1) mflush = 0;
      mfptr = (mfptr + 1) % SLOTS;
    end else if (fl) begin mflush = 1; mfptr = 0; end
  endtask

  task automatic cyc(bit v, int a, int n, bit fl, bit pop);
    @(negedge clk);
    snoop_valid = v; snoop_addr = 16'(a); snoop_node = 2'(n); flush_req = fl; ring_pop = pop;
    mstep(v, a, n, fl, pop);
    @(posedge clk); #1;
    chk(rec_wr_en == e_wr, "R6", "rec_wr_en", rec_wr_en, e_wr);
    if (e_wr && rec_wr_en) begin
      chk(rec_wr_addr == 3'(e_addr), "R6", "rec_wr_addr", rec_wr_addr, e_addr);
      chk(rec_page == 8'(e_page) && rec_node == 2'(e_node), "R2", "record tag",
          {rec_page, rec_node}, (e_page << 2) | e_node);
      chk(rec_count == 4'(e_cnt), "R1", "record count", rec_count, e_cnt);
    end
    if (rec_wr_en && cap_n < 1024) begin
      cap_page[cap_n] = rec_page; cap_node[cap_n] = rec_node; cap_cnt[cap_n] = rec_count; cap_n++;
    end
    chk(ring_head == 3'(mhead) && ring_tail == 3'(mtail), "R7", "pointers",
        {ring_head, ring_tail}, (mhead << 3) | mtail);
    chk(ring_level == 4'(mlevel), "R7", "ring_level", ring_level, mlevel);
    chk(lost_flag == mlost && drop_count == 8'(mdrop), "R8", "loss state",
        {lost_flag, drop_count}, (int'(mlost) << 8) | mdrop);
    chk(flush_done == e_done && flush_busy == mflush, "R9", "flush state",
        {flush_busy, flush_done}, (int'(mflush) << 1) | int'(e_done));
  endtask

  task automatic idle(int k); for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0); endtask
  task automatic flush_all(); cyc(0, 0, 0, 1, 0); idle(SLOTS); endtask
  task automatic drain(); while (mlevel > 0) cyc(0, 0, 0, 0, 1); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b;
    for (int i = 0; i < SLOTS; i++) begin mv[i] = 0; mpage[i] = 0; mnode[i] = 0; mcnt[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(!rec_wr_en && ring_level == 0 && ring_head == 0 && !lost_flag && drop_count == 0
        && !flush_busy && !flush_done, "R11", "reset outputs", ring_level, 0);
    @(negedge clk); rst_n = 1;

    b = cap_n;
    cyc(1, 16'h0105, 0, 0, 0); cyc(1, 16'h01F0, 0, 0, 0);
    cyc(1, 16'h0105, 1, 0, 0); cyc(1, 16'h0200, 0, 0, 0);
    flush_all();
    chk(cap_n == b + 3, "R9", "flush record count", cap_n - b, 3);
    chk(cap_page[b] == 1 && cap_node[b] == 0 && cap_cnt[b] == 2, "R2", "offset shares counter", cap_cnt[b], 2);
    chk(cap_page[b+1] == 1 && cap_node[b+1] == 1 && cap_cnt[b+1] == 1, "R2", "node separates", cap_node[b+1], 1);
    chk(cap_page[b+2] == 2 && cap_cnt[b+2] == 1, "R3", "lowest free slot", cap_page[b+2], 2);
    drain();
    cyc(0, 0, 0, 0, 1);
    chk(ring_level == 0, "R7", "pop on empty ignored", ring_level, 0);

    for (int p = 10; p < 14; p++) cyc(1, p << 8, 2, 0, 0);
    b = cap_n;
    cyc(1, 20 << 8, 2, 0, 0);
    chk(cap_n == b + 1 && cap_page[b] == 10 && cap_cnt[b] == 1, "R4", "first victim slot 0", cap_page[b], 10);
    cyc(1, 21 << 8, 2, 0, 0);
    chk(cap_page[b+1] == 11, "R4", "victim advances", cap_page[b+1], 11);
    flush_all(); drain();

    b = cap_n;
    for (int k = 0; k < LIMIT; k++) cyc(1, 16'h3000 + k, 3, 0, 0);
    chk(cap_n == b + 1 && cap_cnt[b] == LIMIT && cap_page[b] == 16'h30, "R5", "overflow record", cap_cnt[b], LIMIT);
    cyc(1, 16'h3000, 3, 0, 0);
    flush_all();
    chk(cap_n == b + 2 && cap_cnt[b+1] == 1 && cap_page[b+1] == 16'h30, "R5", "slot kept after overflow", cap_cnt[b+1], 1);
    drain();

    for (int p = 0; p < 32; p++) cyc(1, p << 8, 1, 0, 0);
    chk(ring_level == DEPTH && lost_flag && drop_count == 20, "R8", "ring full drops", drop_count, 20);
    drain();
    chk(lost_flag, "R8", "lost flag sticky", lost_flag, 1);
    flush_all(); drain();

    cyc(1, 16'h4000, 0, 0, 0);
    b = mdrop;
    cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < SLOTS; i++) cyc(1, 16'h4000, 0, 0, 0);
    chk(drop_count == 8'(b + SLOTS), "R10", "snoops during flush dropped", drop_count, b + SLOTS);
    b = cap_n;
    flush_all();
    chk(cap_n == b, "R10", "no counter made during flush", cap_n - b, 0);
    drain();

    for (int i = 0; i < 3000; i++)
      cyc((i % 5) != 4, (((i * 7) % 6) << 8) | (i & 255), (i / 3) % 2,
          (i % 97) == 50, (i % 3) != 0);
    flush_all(); drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule